// File: doc/BRIEF.md
# Bus-Mapped Countdown Timer Bank

A bank of independent 32-bit down-counters, each set up and observed through an APB slave port that runs on the same clock as the counters. Every channel holds a reload value, a control word, a sticky expiry flag and one interrupt line. Software writes a start value while the channel is stopped. It then sets the run bit, and the counter starts from the stored value on the next clock.

When a counter reaches zero it either wraps to all ones (free-running) or restarts from the stored value (periodic), and on that same clock it raises its expiry flag. The flag stays set until a read of a clear register drops it. A mask bit gates the flag onto the interrupt pin without touching the flag. Bank-wide registers collect the masked and unmasked flags of all channels, clear all flags with one read, and return a fixed version word.

Top module: `apb_timer_bank`

## Requirements
- R1: Channel n occupies word-aligned byte addresses n*0x14 + {0x00 reload value, 0x04 live count, 0x08 control, 0x0C clear-on-read, 0x10 masked flag}. The bank words are 0xA0 masked flags, 0xA4 clear-all-on-read, 0xA8 unmasked flags and 0xAC version. Bit n of each bank flag word is channel n. Any other address, and any address with bits [1:0] non-zero, reads as zero.
- R2: Control bit 0 is run, bit 1 is mode (1 periodic, 0 free-running) and bit 2 is mask (1 hides the interrupt). The reload value and the control bits read back as written.
- R3: On the clock where run goes from 0 to 1, the live count takes the reload value. On every later clock with run set, it drops by one.
- R4: In free-running mode a count of 0 becomes 0xFFFFFFFF on the next clock.
- R5: In periodic mode a count of 0 becomes the reload value on the next clock.
- R6: The unmasked flag sets on the clock where the count leaves 0 with run set, and then holds whatever the mask bit is set to.
- R7: irq_o[n], the channel masked-flag word and bit n of 0xA0 all equal the flag AND NOT mask. Bit n of 0xA8 equals the flag.
- R8: A read of a channel's clear register drops only that channel's flag. A read of 0xA4 drops every flag.
- R9: Clearing run freezes the live count and leaves the flag as it is. Setting run again restarts the count from the reload value.
- R10: Writes to the live count, clear, masked-flag, bank and version addresses change no state.
- R11: pready_o is always 1 and pslverr_o is always 0. Read data is valid during the access phase of the same transfer.
- R12: After reset the reload values, control words, counts and flags are all zero and every interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and counting clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB access phase |
| pwrite_i | input | 1 | APB write when high |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | DATA_W | APB write data |
| prdata_o | output | DATA_W | APB read data |
| pready_o | output | 1 | Always ready |
| pslverr_o | output | 1 | Never an error |
| irq_o | output | NUM_TIMERS | Per-channel masked interrupt |

## Verification
The hardest states to reach are the wrap from zero in free-running mode and repeated expiry in periodic mode, because a natural count would need billions of clocks. The bench loads 0, 2 or 3 and counts the exact number of clocks, including the one taken by the stopping write, before it freezes the counter and reads it back. A flag held while the channel is stopped or masked, and a clear that hits one channel but not its neighbours, are reached by setting flags on all channels first and then reading the clear registers one by one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CHAN_WORDS  = 5;
  localparam int unsigned BANK_WORD   = 40;  // 0xA0 >> 2

  typedef enum logic [2:0] {
    REG_LOAD = 3'd0,
    REG_CUR  = 3'd1,
    REG_CTRL = 3'd2,
    REG_EOI  = 3'd3,
    REG_STAT = 3'd4
  } chan_reg_e;

  typedef struct packed {
    logic mask;
    logic periodic;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_TIMERS = 3,
  parameter int unsigned ADDR_W     = 8,
  localparam int unsigned WORD_W    = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0]     paddr_i,
  output logic [NUM_TIMERS-1:0] chan_hit_o,
  output chan_reg_e             reg_o,
  output logic                  all_stat_o,
  output logic                  all_eoi_o,
  output logic                  all_raw_o,
  output logic                  ver_o
);
  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = paddr_i[ADDR_W-1:2];
  assign aligned = (paddr_i[1:0] == 2'b00);

  for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_hit
    assign chan_hit_o[n] = aligned &&
                           (word >= WORD_W'(n*CHAN_WORDS)) &&
                           (word <  WORD_W'(n*CHAN_WORDS + CHAN_WORDS));
  end

  always_comb begin
    reg_o = REG_LOAD;
    for (int n = 0; n < NUM_TIMERS; n++)
      if (chan_hit_o[n]) reg_o = chan_reg_e'(3'(word - WORD_W'(n*CHAN_WORDS)));
  end

  assign all_stat_o = aligned && (word == WORD_W'(BANK_WORD));
  assign all_eoi_o  = aligned && (word == WORD_W'(BANK_WORD + 1));
  assign all_raw_o  = aligned && (word == WORD_W'(BANK_WORD + 2));
  assign ver_o      = aligned && (word == WORD_W'(BANK_WORD + 3));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_we_i,
  input  logic              ctrl_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] cnt_o,
  output ctrl_t             ctrl_o,
  output logic              raw_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] load_q, cnt_q;
  ctrl_t             ctrl_q;
  logic              raw_q;
  logic              start, expire;

  assign start  = ctrl_we_i && wdata_i[0] && !ctrl_q.run;
  assign expire = ctrl_q.run && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      raw_q  <= 1'b0;
    end else begin
      if (load_we_i) load_q <= wdata_i;
      if (ctrl_we_i) ctrl_q <= ctrl_t'(wdata_i[2:0]);
      if (start)            cnt_q <= load_q;
      else if (ctrl_q.run)  cnt_q <= (cnt_q == '0) ? (ctrl_q.periodic ? load_q : '1)
                                                   : cnt_q - 1'b1;
      // a new expiry outranks a clear in the same cycle
      if (expire)     raw_q <= 1'b1;
      else if (clr_i) raw_q <= 1'b0;
    end
  end

  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign ctrl_o = ctrl_q;
  assign raw_o  = raw_q;
  assign irq_o  = raw_q && !ctrl_q.mask;

  assert_load_on_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> cnt_o == $past(load_o));
  assert_count_down_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o.run && cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1);
  assert_wrap_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o.run && cnt_o == '0 && !ctrl_o.periodic) |=> &cnt_o);
  assert_reload_periodic_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o.run && cnt_o == '0 && ctrl_o.periodic && !load_we_i) |=> cnt_o == $past(load_o));
  assert_flag_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_o.run && cnt_o == '0) |=> raw_o);
  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o && !clr_i) |=> raw_o);
  assert_freeze_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o.run && !start) |=> $stable(cnt_o));
endmodule

// File: rtl/apb_timer_bank.sv
module apb_timer_bank
  import tmr_pkg::*;
#(
  parameter int unsigned   NUM_TIMERS = 3,
  parameter int unsigned   ADDR_W     = 8,
  parameter int unsigned   DATA_W     = 32,
  parameter logic [31:0]   VERSION_ID = 32'h0001_0300
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  psel_i,
  input  logic                  penable_i,
  input  logic                  pwrite_i,
  input  logic [ADDR_W-1:0]     paddr_i,
  input  logic [DATA_W-1:0]     pwdata_i,
  output logic [DATA_W-1:0]     prdata_o,
  output logic                  pready_o,
  output logic                  pslverr_o,
  output logic [NUM_TIMERS-1:0] irq_o
);
  logic                  access, wr, rd;
  logic [NUM_TIMERS-1:0] chan_hit, raw_v;
  chan_reg_e             reg_sel;
  logic                  all_stat, all_eoi, all_raw, ver_hit;
  logic [DATA_W-1:0]     load_a [NUM_TIMERS];
  logic [DATA_W-1:0]     cnt_a  [NUM_TIMERS];
  ctrl_t                 ctrl_a [NUM_TIMERS];

  assign access    = psel_i && penable_i;
  assign wr        = access && pwrite_i;
  assign rd        = access && !pwrite_i;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;

  tmr_addr_dec #(.NUM_TIMERS(NUM_TIMERS), .ADDR_W(ADDR_W)) u_dec (
    .paddr_i    (paddr_i),
    .chan_hit_o (chan_hit),
    .reg_o      (reg_sel),
    .all_stat_o (all_stat),
    .all_eoi_o  (all_eoi),
    .all_raw_o  (all_raw),
    .ver_o      (ver_hit)
  );

  for (genvar n = 0; n < NUM_TIMERS; n++) begin : g_chan
    tmr_channel #(.DATA_W(DATA_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_we_i (wr && chan_hit[n] && reg_sel == REG_LOAD),
      .ctrl_we_i (wr && chan_hit[n] && reg_sel == REG_CTRL),
      .wdata_i   (pwdata_i),
      .clr_i     (rd && (all_eoi || (chan_hit[n] && reg_sel == REG_EOI))),
      .load_o    (load_a[n]),
      .cnt_o     (cnt_a[n]),
      .ctrl_o    (ctrl_a[n]),
      .raw_o     (raw_v[n]),
      .irq_o     (irq_o[n])
    );
  end

  always_comb begin
    prdata_o = '0;
    if (psel_i && !pwrite_i) begin
      for (int n = 0; n < NUM_TIMERS; n++) begin
        if (chan_hit[n]) begin
          unique case (reg_sel)
            REG_LOAD: prdata_o = load_a[n];
            REG_CUR:  prdata_o = cnt_a[n];
            REG_CTRL: prdata_o[2:0] = ctrl_a[n];
            REG_STAT: prdata_o[0] = irq_o[n];
            default:  prdata_o = '0;
          endcase
        end
      end
      if (all_stat) prdata_o[NUM_TIMERS-1:0] = irq_o;
      if (all_raw)  prdata_o[NUM_TIMERS-1:0] = raw_v;
      if (ver_hit)  prdata_o = DATA_W'(VERSION_ID);
    end
  end

  assert_resp_ok_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psel_i |-> (pready_o && !pslverr_o));
  assert_onehot_chan_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(chan_hit));
endmodule

// File: tb/apb_timer_bank_bench.sv
module apb_timer_bank_bench;
  localparam int NT = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]    paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready, pslverr;
  logic [NT-1:0] irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  apb_timer_bank #(.NUM_TIMERS(NT)) u_apb_timer_bank (
    .clk_i(clk), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .irq_o(irq)
  );

  typedef struct packed {
    logic [1:0]  ch;
    logic        mask;
    logic        per;
    logic [31:0] load;
    logic [7:0]  k;
    logic [31:0] cur;
    logic        raw;
  } vec_t;

  // count takes k+2 steps: k idle clocks plus the two clocks of the stopping write
  localparam vec_t VECS [7] = '{
    '{2'd0, 1'b0, 1'b0, 32'd10,  8'd3,  32'd5,          1'b0},
    '{2'd1, 1'b0, 1'b0, 32'd3,   8'd2,  32'hFFFF_FFFF,  1'b1},
    '{2'd2, 1'b1, 1'b1, 32'd3,   8'd2,  32'd3,          1'b1},
    '{2'd0, 1'b0, 1'b1, 32'd2,   8'd5,  32'd1,          1'b1},
    '{2'd1, 1'b1, 1'b0, 32'd0,   8'd0,  32'hFFFF_FFFE,  1'b1},
    '{2'd2, 1'b0, 1'b1, 32'd0,   8'd1,  32'd0,          1'b1},
    '{2'd0, 1'b0, 1'b1, 32'd100, 8'd10, 32'd88,         1'b0}
  };

  function automatic logic [7:0] ca(input int ch, input int off);
    return 8'(ch*20 + off);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk); penable = 1'b1;
    #1 d = prdata;
    chk("R11 pready/pslverr", {30'd0, pready, pslverr}, 32'd2);
    @(negedge clk); psel = 1'b0; penable = 1'b0;
  endtask

  initial begin : wdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d, d2;
    vec_t v;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 irq", 32'(irq), 32'd0);
    rd(ca(0, 'h00), d); chk("R12 load", d, 0);
    rd(ca(1, 'h08), d); chk("R12 ctrl", d, 0);
    rd(ca(2, 'h04), d); chk("R12 count", d, 0);
    rd(8'hA8, d);       chk("R12 raw", d, 0);

    // R1 R2 readback, version, unmapped
    wr(ca(2, 'h00), 32'hDEAD_BEEF);
    rd(ca(2, 'h00), d); chk("R2 load readback", d, 32'hDEAD_BEEF);
    wr(ca(2, 'h08), 32'h6);
    rd(ca(2, 'h08), d); chk("R2 ctrl readback", d, 32'h6);
    wr(ca(2, 'h08), 32'h0);
    rd(8'hAC, d); chk("R1 version", d, 32'h0001_0300);
    rd(8'h3C, d); chk("R1 unmapped 0x3C", d, 0);
    rd(8'hB0, d); chk("R1 unmapped 0xB0", d, 0);
    rd(8'h02, d); chk("R1 unaligned", d, 0);

    // vector table: R3 R4 R5 R6 R7
    for (int i = 0; i < 7; i++) begin
      v = VECS[i];
      rd(ca(int'(v.ch), 'h0C), d);
      wr(ca(int'(v.ch), 'h00), v.load);
      wr(ca(int'(v.ch), 'h08), {29'd0, v.mask, v.per, 1'b1});
      repeat (int'(v.k)) @(negedge clk);
      wr(ca(int'(v.ch), 'h08), {29'd0, v.mask, v.per, 1'b0});
      rd(ca(int'(v.ch), 'h04), d); chk("R3/R4/R5 count", d, v.cur);
      rd(8'hA8, d); chk("R6 raw flag", 32'(d[v.ch]), 32'(v.raw));
      chk("R7 irq pin", 32'(irq[v.ch]), 32'(v.raw & ~v.mask));
      rd(ca(int'(v.ch), 'h10), d); chk("R7 chan status", d, 32'(v.raw & ~v.mask));
      rd(8'hA0, d); chk("R7 bank masked", 32'(d[v.ch]), 32'(v.raw & ~v.mask));
    end

    // R9 freeze and restart
    rd(8'hA4, d);
    rd(8'hA8, d); chk("R8 clear-all", d, 0);
    wr(ca(1, 'h00), 32'd50);
    wr(ca(1, 'h08), 32'h1);
    repeat (4) @(negedge clk);
    wr(ca(1, 'h08), 32'h0);
    rd(ca(1, 'h04), d); chk("R9 frozen count", d, 32'd44);
    repeat (5) @(negedge clk);
    rd(ca(1, 'h04), d); chk("R9 still frozen", d, 32'd44);
    wr(ca(1, 'h00), 32'd0);
    wr(ca(1, 'h08), 32'h1);
    wr(ca(1, 'h08), 32'h0);
    repeat (4) @(negedge clk);
    rd(8'hA8, d); chk("R9 flag held while stopped", d, 32'b010);
    wr(ca(1, 'h00), 32'd7);
    wr(ca(1, 'h08), 32'h1);
    rd(ca(1, 'h04), d); chk("R9 restart from reload", d, 32'd6);
    wr(ca(1, 'h08), 32'h0);

    // R10 writes to read-only locations
    rd(ca(1, 'h04), d);
    wr(ca(1, 'h04), 32'h1234);
    rd(ca(1, 'h04), d2); chk("R10 count write ignored", d2, d);
    wr(ca(1, 'h0C), 32'h0);
    wr(ca(1, 'h10), 32'h0);
    wr(8'hA4, 32'h0);
    wr(8'hA8, 32'h0);
    rd(8'hA8, d); chk("R10 flag survives writes", d, 32'b010);
    wr(8'hAC, 32'h0);
    rd(8'hAC, d); chk("R10 version write ignored", d, 32'h0001_0300);

    // R8 per-channel vs bank clear
    for (int c = 0; c < NT; c++) begin
      wr(ca(c, 'h00), 32'd0);
      wr(ca(c, 'h08), 32'h1);
      wr(ca(c, 'h08), 32'h0);
    end
    rd(8'hA8, d); chk("R8 all flags set", d, 32'b111);
    rd(ca(1, 'h0C), d); chk("R8 clear read data", d, 0);
    rd(8'hA8, d); chk("R8 single clear", d, 32'b101);
    chk("R8 irq after single clear", 32'(irq), 32'b101);
    rd(8'hA4, d);
    rd(8'hA8, d); chk("R8 bank clear", d, 0);
    chk("R8 irq after bank clear", 32'(irq), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule